// File: doc/BRIEF.md
# Averaged Power Spectrum Accumulator

This block turns a stream of complex frequency bins into an averaged power spectrum. A transform upstream delivers one segment at a time: every bin arrives with its index and signed real and imaginary parts. The block squares the magnitude of each bin and adds it into a storage slot owned by that bin index. When the configured number of segments has been gathered, it divides every slot by that count and streams the averaged spectrum out in ascending bin order.

The segment count is always a power of two, selected by a small exponent input, so the division is a right shift. The first segment of each batch writes its slots directly rather than adding to them, so consecutive batches need no clearing pass in between. The storage is wide enough that a full batch of worst-case bins cannot wrap. The averaged value is clamped to the output width.

Top module: `psd_avg_top`

## Requirements
- R1: After reset, outValid and outLast are low and stay low until a batch completes.
- R2: The power of an accepted bin is re*re + im*im, where binRe and binIm are signed two's complement values of DATA_W bits.
- R3: The first segment of each batch overwrites each bin's slot, so values from an earlier batch never reach a later batch's result.
- R4: A batch holds 2^segLog2 segments; a segment ends when a bin with index NBINS-1 is accepted, and the batch ends on that bin in the last segment.
- R5: The reported power of each bin is the floor of the sum of its powers over the batch divided by 2^segLog2.
- R6: A reported power above 2^OUT_W-1 is replaced by 2^OUT_W-1.
- R7: A slot never wraps while a batch is gathered, for any bin values and any segment count up to 2^LOG2_L_MAX.
- R8: The first result appears on the second rising edge after the edge that accepts the batch's final bin; results then follow on consecutive cycles for bins 0 to NBINS-1, outLast is high only with bin NBINS-1, and outValid drops on the next cycle.
- R9: segLog2 is sampled with the first bin accepted in a batch; changes later in the same batch have no effect on its length or its scaling.
- R10: Cycles with binValid low between bins have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| binValid | input | 1 | Bin inputs carry a bin this cycle |
| binIdx | input | $clog2(NBINS) | Index of the bin presented |
| binRe | input | DATA_W | Real part, signed |
| binIm | input | DATA_W | Imaginary part, signed |
| segLog2 | input | $clog2(LOG2_L_MAX+1) | Exponent of the segment count per batch |
| outValid | output | 1 | A result is presented |
| outLast | output | 1 | The result is for the highest bin |
| outIdx | output | $clog2(NBINS) | Bin index of the result |
| outPower | output | OUT_W | Averaged, clamped power of the bin |

## Verification
On every cycle the assertions check that slot additions never wrap, that the read-out runs from bin zero in consecutive order and ends with its flag on the top bin followed by an idle cycle, that the segment counter stays within the latched count, and that the latched exponent holds for the whole batch. Only the bench scenarios show the arithmetic itself: the squared magnitudes, the averaging for each segment count, clamping of large averages, overwrite on the first segment after a previous batch, the effect of idle gaps, and the exact cycle of the first result.

// File: rtl/psd_avg_pkg.sv
package psd_avg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_DRAIN,
    ST_READ
  } psd_state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;    // take the presented bin into the pipeline
    logic firstSeg;  // bin belongs to the first segment: overwrite
    logic rdEn;      // present one result this cycle
    logic rdLast;    // result being presented is the top bin
  } psd_strobe_t;

endpackage

// File: rtl/psd_avg_ctrl.sv
module psd_avg_ctrl
  import psd_avg_pkg::*;
#(
  parameter int NBINS      = 16,
  parameter int LOG2_L_MAX = 3
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               binValid,
  input  logic [$clog2(NBINS)-1:0]           binIdx,
  input  logic [$clog2(LOG2_L_MAX+1)-1:0]    segLog2,
  output psd_strobe_t                        strobe,
  output logic [$clog2(NBINS)-1:0]           rdIdx,
  output logic [$clog2(LOG2_L_MAX+1)-1:0]    shiftAmt
);

  localparam int IDX_W = $clog2(NBINS);
  localparam int CFG_W = $clog2(LOG2_L_MAX + 1);
  localparam int CNT_W = LOG2_L_MAX + 1;

  psd_state_e       state;
  logic [CNT_W-1:0] segCnt;
  logic [CFG_W-1:0] cfgReg;
  logic [CFG_W-1:0] lNow;
  logic [CNT_W-1:0] segTop;
  logic [IDX_W-1:0] rdIdxQ;
  logic             accept;
  logic             binEnd;
  logic             batchEnd;

  always_comb begin
    lNow     = (state == ST_IDLE) ? segLog2 : cfgReg;
    segTop   = (CNT_W'(1) << lNow) - CNT_W'(1);
    accept   = binValid && (state == ST_IDLE || state == ST_ACC);
    binEnd   = accept && (binIdx == IDX_W'(NBINS - 1));
    batchEnd = binEnd && (segCnt == segTop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      segCnt <= '0;
      cfgReg <= '0;
      rdIdxQ <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_ACC: begin
          if (accept) begin
            if (state == ST_IDLE) cfgReg <= segLog2;
            if (batchEnd) begin
              state  <= ST_DRAIN;
              segCnt <= '0;
            end else begin
              state <= ST_ACC;
              if (binEnd) segCnt <= segCnt + CNT_W'(1);
            end
          end
        end
        ST_DRAIN: begin
          state  <= ST_READ;
          rdIdxQ <= '0;
        end
        default: begin
          rdIdxQ <= rdIdxQ + IDX_W'(1);
          if (rdIdxQ == IDX_W'(NBINS - 1)) state <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    strobe.accept   = accept;
    strobe.firstSeg = (segCnt == '0);
    strobe.rdEn     = (state == ST_READ);
    strobe.rdLast   = (state == ST_READ) && (rdIdxQ == IDX_W'(NBINS - 1));
    rdIdx           = rdIdxQ;
    shiftAmt        = cfgReg;
  end

  // R4: the segment counter never passes the latched segment count
  assert_seg_in_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACC) |-> (segCnt <= ((CNT_W'(1) << cfgReg) - CNT_W'(1))));

  // R9: once a batch has started, the latched exponent holds
  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> $stable(cfgReg));

endmodule

// File: rtl/psd_avg_datapath.sv
module psd_avg_datapath
  import psd_avg_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int NBINS      = 16,
  parameter int LOG2_L_MAX = 3,
  parameter int OUT_W      = 20
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  psd_strobe_t                        strobe,
  input  logic [$clog2(NBINS)-1:0]           binIdx,
  input  logic signed [DATA_W-1:0]           binRe,
  input  logic signed [DATA_W-1:0]           binIm,
  input  logic [$clog2(NBINS)-1:0]           rdIdx,
  input  logic [$clog2(LOG2_L_MAX+1)-1:0]    shiftAmt,
  output logic                               outValid,
  output logic                               outLast,
  output logic [$clog2(NBINS)-1:0]           outIdx,
  output logic [OUT_W-1:0]                   outPower
);

  localparam int IDX_W = $clog2(NBINS);
  localparam int SQ_W  = 2 * DATA_W;
  localparam int ACC_W = SQ_W + LOG2_L_MAX;

  logic signed [SQ_W-1:0] reSq;
  logic signed [SQ_W-1:0] imSq;
  logic [SQ_W-1:0]        sqSum;

  logic                   s1Valid;
  logic                   s1First;
  logic [IDX_W-1:0]       s1Idx;
  logic [SQ_W-1:0]        s1Sq;

  logic [ACC_W-1:0]       accMem [NBINS];
  logic [ACC_W-1:0]       shifted;
  logic [OUT_W-1:0]       clamped;

  always_comb begin
    reSq  = binRe * binRe;
    imSq  = binIm * binIm;
    sqSum = $unsigned(reSq) + $unsigned(imSq);
  end

  // Stage 1: squared magnitude register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1First <= 1'b0;
      s1Idx   <= '0;
      s1Sq    <= '0;
    end else begin
      s1Valid <= strobe.accept;
      if (strobe.accept) begin
        s1First <= strobe.firstSeg;
        s1Idx   <= binIdx;
        s1Sq    <= sqSum;
      end
    end
  end

  // Stage 2: read-modify-write of the bin slot
  always_ff @(posedge clk) begin
    if (s1Valid) begin
      if (s1First) accMem[s1Idx] <= ACC_W'(s1Sq);
      else         accMem[s1Idx] <= accMem[s1Idx] + ACC_W'(s1Sq);
    end
  end

  // Read-out: scale by the segment count, clamp to the output width
  always_comb begin
    shifted = accMem[rdIdx] >> shiftAmt;
    if (|(shifted >> OUT_W)) clamped = '1;
    else                     clamped = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLast  <= 1'b0;
      outIdx   <= '0;
      outPower <= '0;
    end else begin
      outValid <= strobe.rdEn;
      outLast  <= strobe.rdLast;
      if (strobe.rdEn) begin
        outIdx   <= rdIdx;
        outPower <= clamped;
      end
    end
  end

  // R7: an accumulating write never carries out of the slot width
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    (s1Valid && !s1First) |->
      !(({1'b0, accMem[s1Idx]} + (ACC_W+1)'(s1Sq)) >> ACC_W));

  // R8: read-out starts at bin zero
  assert_start_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outIdx == '0));

  // R8: consecutive bins on consecutive cycles
  assert_order_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outLast) |=> (outValid && outIdx == $past(outIdx) + IDX_W'(1)));

  // R8: last flag only on the top bin, then the stream stops
  assert_last_top_R8: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> (outValid && outIdx == IDX_W'(NBINS - 1)));

  assert_last_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> !outValid);

endmodule

// File: rtl/psd_avg_top.sv
module psd_avg_top
  import psd_avg_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int NBINS      = 16,
  parameter int LOG2_L_MAX = 3,
  parameter int OUT_W      = 20
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               binValid,
  input  logic [$clog2(NBINS)-1:0]           binIdx,
  input  logic signed [DATA_W-1:0]           binRe,
  input  logic signed [DATA_W-1:0]           binIm,
  input  logic [$clog2(LOG2_L_MAX+1)-1:0]    segLog2,
  output logic                               outValid,
  output logic                               outLast,
  output logic [$clog2(NBINS)-1:0]           outIdx,
  output logic [OUT_W-1:0]                   outPower
);

  localparam int IDX_W = $clog2(NBINS);
  localparam int CFG_W = $clog2(LOG2_L_MAX + 1);

  psd_strobe_t      strobe;
  logic [IDX_W-1:0] rdIdx;
  logic [CFG_W-1:0] shiftAmt;

  psd_avg_ctrl #(
    .NBINS      (NBINS),
    .LOG2_L_MAX (LOG2_L_MAX)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .binValid (binValid),
    .binIdx   (binIdx),
    .segLog2  (segLog2),
    .strobe   (strobe),
    .rdIdx    (rdIdx),
    .shiftAmt (shiftAmt)
  );

  psd_avg_datapath #(
    .DATA_W     (DATA_W),
    .NBINS      (NBINS),
    .LOG2_L_MAX (LOG2_L_MAX),
    .OUT_W      (OUT_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .binIdx   (binIdx),
    .binRe    (binRe),
    .binIm    (binIm),
    .rdIdx    (rdIdx),
    .shiftAmt (shiftAmt),
    .outValid (outValid),
    .outLast  (outLast),
    .outIdx   (outIdx),
    .outPower (outPower)
  );

endmodule

// File: tb/psd_avg_top_tb_top.sv
`timescale 1ns/1ps
module psd_avg_top_tb_top;

  localparam int DW   = 12;
  localparam int NB   = 16;
  localparam int LMX  = 3;
  localparam int OW   = 20;
  localparam longint OMAX = (64'd1 << OW) - 1;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 binValid = 1'b0;
  logic [3:0]           binIdx = '0;
  logic signed [DW-1:0] binRe = '0;
  logic signed [DW-1:0] binIm = '0;
  logic [1:0]           segLog2 = '0;
  logic                 outValid;
  logic                 outLast;
  logic [3:0]           outIdx;
  logic [OW-1:0]        outPower;

  int  compared = 0;
  int  mismatched = 0;
  bit  expectOut = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  psd_avg_top #(.DATA_W(DW), .NBINS(NB), .LOG2_L_MAX(LMX), .OUT_W(OW)) dut_i (
    .clk(clk), .rstN(rstN), .binValid(binValid), .binIdx(binIdx),
    .binRe(binRe), .binIm(binIm), .segLog2(segLog2),
    .outValid(outValid), .outLast(outLast), .outIdx(outIdx), .outPower(outPower)
  );

  task automatic chk(string req, longint act, longint exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R8: outside an expected read-out window no result may appear
  always @(negedge clk) begin
    if (rstN && !expectOut && !done) chk("R8 idle stream", longint'(outValid), 0);
  end

  // mode 0 random, 1 max magnitude, 2 small, 3 deterministic per bin
  task automatic runBatch(int lg, int mode, bit cfgChange, bit gaps, string tag);
    longint sums [NB];
    int     L = 1 << lg;
    for (int b = 0; b < NB; b++) sums[b] = 0;
    for (int s = 0; s < L; s++) begin
      for (int b = 0; b < NB; b++) begin
        int re;
        int im;
        if (gaps && ($urandom % 3 == 0)) begin
          @(negedge clk);
          binValid = 1'b0;
          binRe = DW'(12'sd1000);
          binIm = DW'(-12'sd1000);
        end
        case (mode)
          0: begin re = int'($urandom_range(4095)) - 2048; im = int'($urandom_range(4095)) - 2048; end
          1: begin re = -2048; im = -2048; end
          2: begin re = int'($urandom_range(15)) - 8; im = int'($urandom_range(15)) - 8; end
          default: begin re = -b; im = b + 1; end
        endcase
        sums[b] += longint'(re * re + im * im);
        @(negedge clk);
        binValid = 1'b1;
        binIdx   = 4'(b);
        binRe    = DW'(re);
        binIm    = DW'(im);
        if (s == 0 && b == 0) segLog2 = 2'(lg);
        else if (cfgChange) segLog2 = 2'((lg + 1) % 4);
      end
    end
    @(negedge clk);
    binValid = 1'b0;
    expectOut = 1'b1;
    chk({tag, " R8 no result one cycle after final bin"}, longint'(outValid), 0);
    @(negedge clk);
    chk({tag, " R8 no result two cycles after final bin"}, longint'(outValid), 0);
    for (int k = 0; k < NB; k++) begin
      longint e = sums[k] >> lg;
      if (e > OMAX) e = OMAX;
      @(negedge clk);
      chk({tag, " R8 valid"}, longint'(outValid), 1);
      chk({tag, " R8 index"}, longint'(outIdx), k);
      chk({tag, " R8 last"}, longint'(outLast), (k == NB - 1) ? 1 : 0);
      chk({tag, " R5 power"}, longint'(outPower), e);
    end
    @(negedge clk);
    chk({tag, " R8 stream ends"}, longint'(outValid), 0);
    expectOut = 1'b0;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outValid", longint'(outValid), 0);
    chk("R1 reset outLast", longint'(outLast), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset", longint'(outValid), 0);

    runBatch(0, 3, 1'b0, 1'b0, "R2 deterministic L=1");
    runBatch(0, 0, 1'b0, 1'b0, "R2 random L=1");
    runBatch(1, 0, 1'b0, 1'b0, "R4 random L=2");
    runBatch(2, 0, 1'b0, 1'b1, "R10 gaps L=4");
    runBatch(3, 0, 1'b0, 1'b0, "R4 random L=8");
    runBatch(3, 1, 1'b0, 1'b0, "R6 R7 max magnitude L=8");
    runBatch(1, 2, 1'b0, 1'b0, "R3 small after large L=2");
    runBatch(2, 0, 1'b1, 1'b0, "R9 config change L=4");
    runBatch(1, 1, 1'b1, 1'b1, "R9 R10 change with gaps L=2");
    runBatch(0, 2, 1'b0, 1'b1, "R3 small L=1");
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule